// File: doc/BRIEF.md
# Control Port Command Decoder

This block interprets 16-bit words written to the control port of a video controller. A word either updates one entry of the controller's register file, or it is one half of a two-word command. Together the two halves build a 16-bit memory address and a 6-bit access code. The decoder tracks which half it expects next with a pending flag. A read of the status or data port abandons a command that is only half written.

When the second half sets the top bit of the access code, the decoder deals with the transfer engine. For copy and external-bus transfers it pulses a start strobe as soon as the command completes. For an external-bus transfer it also pulses a stall request to the host processor. A fill transfer does not start then. The decoder arms it instead, and the next data-port write starts it.

The register file, the transfer engine and the memories sit outside this block. The engine's mode comes in on `dma_mode`, which carries bits 7:6 of the source-high register.

Top module: `ctrl_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it, `cmd_pending`, `cmd_addr`, `cmd_code`, `reg_we`, `dma_start`, `cpu_stall` and `fill_armed` are all zero.
- R2: A control write with no command pending and `ctl_wdata[15:14]` = 2'b10 is a register write. In the next cycle `reg_we` is high for exactly one cycle, with `reg_idx` = `ctl_wdata[12:8]` and `reg_wdata` = `ctl_wdata[7:0]`. Address, code and pending flag do not change.
- R3: A register write whose index is 24 or more produces no `reg_we` pulse. Index 23 is accepted.
- R4: A control write with no command pending and `ctl_wdata[15:14]` other than 2'b10 is a first word. It loads `cmd_addr[13:0]` from `ctl_wdata[13:0]` and `cmd_code[1:0]` from `ctl_wdata[15:14]`, keeps `cmd_addr[15:14]` and `cmd_code[5:2]`, and sets `cmd_pending`. All of this is visible in the next cycle.
- R5: Any control write while a command is pending is a second word, even when its bits 15:14 are 2'b10. It loads `cmd_addr[15:14]` from `ctl_wdata[1:0]` and `cmd_code[5:2]` from `ctl_wdata[7:4]`, keeps the other bits, and clears `cmd_pending`.
- R6: A second word with `ctl_wdata[7]` set (code bit 5) and `dma_mode` not equal to 2'b10 gives a one-cycle `dma_start` in the next cycle. `cpu_stall` pulses with it exactly when `dma_mode[1]` is 0.
- R7: A second word with code bit 5 set and `dma_mode` = 2'b10 (fill) gives no start and sets `fill_armed`. The next `data_wr` gives a one-cycle `dma_start` without `cpu_stall` and clears `fill_armed`. A `data_wr` while not armed has no effect.
- R8: A second word with code bit 5 clear starts nothing and clears `fill_armed`.
- R9: `port_rd` clears `cmd_pending`. A control write in the same cycle is decoded as if no command were pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_wdata | input | 16 | Control port write value |
| port_rd | input | 1 | Status or data port read strobe |
| data_wr | input | 1 | Data port write strobe |
| dma_mode | input | 2 | Transfer mode, bits 7:6 of source-high register |
| reg_we | output | 1 | Register file write strobe |
| reg_idx | output | 5 | Register file index |
| reg_wdata | output | 8 | Register file write data |
| cmd_addr | output | 16 | Assembled command address |
| cmd_code | output | 6 | Assembled access code |
| cmd_pending | output | 1 | First word received, second expected |
| fill_armed | output | 1 | Fill transfer waiting for a data write |
| dma_start | output | 1 | Transfer start pulse |
| cpu_stall | output | 1 | Host stall request pulse for external-bus transfers |

## Verification
A wrong pending flag is the most damaging internal fault. It shows up one cycle after the next control write in two ways: a register write that never strobes `reg_we`, or a second word loaded into the low address bits. Corrupted address or code bits stay visible on `cmd_addr` and `cmd_code` until the next word overwrites them, so they can be checked at any idle point. A lost or stray arm state appears only at the next data-port write, as a missing or extra `dma_start`. For that reason the sequences issue data writes both while armed and while not armed.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 5;
  localparam logic [1:0] REG_TAG   = 2'b10;
  localparam logic [1:0] FILL_MODE = 2'b10;

  typedef enum logic [1:0] {
    CW_NONE,
    CW_REG,
    CW_FIRST,
    CW_SECOND
  } cw_kind_e;
endpackage

// File: rtl/cmd_rst_sync.sv
module cmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/cmd_regwr.sv
module cmd_regwr
  import cmd_dec_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int REG_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_reg,
  input  logic [WORD_W-1:0]    wdata,
  output logic                 reg_we,
  output logic [IDX_W-1:0]     reg_idx,
  output logic [REG_W-1:0]     reg_wdata
);
  logic             we_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = wdata[8 +: IDX_W];
    we_d  = is_reg && (int'(idx_d) < NUM_REGS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_idx   <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= we_d;
      if (we_d) begin
        reg_idx   <= idx_d;
        reg_wdata <= wdata[REG_W-1:0];
      end
    end
  end

  // R3: a strobe never carries an out-of-range index
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (int'(reg_idx) < NUM_REGS));

  // R2: the strobe lasts one cycle unless a new register write arrived
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !is_reg) |=> !reg_we);
endmodule

// File: rtl/cmd_latch.sv
module cmd_latch
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_first,
  input  logic              is_second,
  input  logic              rd_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic              cmd_pending
);
  logic [ADDR_W-1:0] addr_d;
  logic [CODE_W-1:0] code_d;
  logic              pend_d;
  logic              load_en;

  always_comb begin
    addr_d  = cmd_addr;
    code_d  = cmd_code;
    pend_d  = cmd_pending;
    load_en = is_first || is_second || rd_clr;
    if (is_first) begin
      addr_d[13:0] = wdata[13:0];
      code_d[1:0]  = wdata[15:14];
      pend_d       = 1'b1;
    end else if (is_second) begin
      addr_d[15:14] = wdata[1:0];
      code_d[5:2]   = wdata[7:4];
      pend_d        = 1'b0;
    end else if (rd_clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr    <= '0;
      cmd_code    <= '0;
      cmd_pending <= 1'b0;
    end else if (load_en) begin
      cmd_addr    <= addr_d;
      cmd_code    <= code_d;
      cmd_pending <= pend_d;
    end
  end

  // R5: second word keeps the low address bits and low code bits
  a_r5_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    is_second |=> (cmd_addr[13:0] == $past(cmd_addr[13:0])) &&
                  (cmd_code[1:0] == $past(cmd_code[1:0])));

  // R4: first word keeps the high address bits and high code bits
  a_r4_high_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    is_first |=> (cmd_addr[15:14] == $past(cmd_addr[15:14])) &&
                 (cmd_code[5:2] == $past(cmd_code[5:2])));

  // R9: a port read with no first word leaves nothing pending
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !is_first) |=> !cmd_pending);
endmodule

// File: rtl/cmd_dma_ctl.sv
module cmd_dma_ctl
  import cmd_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_second,
  input  logic       code_go,
  input  logic [1:0] dma_mode,
  input  logic       data_wr,
  output logic       dma_start,
  output logic       cpu_stall,
  output logic       fill_armed
);
  logic start_d;
  logic stall_d;
  logic armed_d;

  always_comb begin
    start_d = 1'b0;
    stall_d = 1'b0;
    armed_d = fill_armed;
    if (is_second) begin
      armed_d = 1'b0;
      if (code_go) begin
        if (dma_mode == FILL_MODE) begin
          armed_d = 1'b1;
        end else begin
          start_d = 1'b1;
          stall_d = !dma_mode[1];
        end
      end
    end else if (data_wr && fill_armed) begin
      start_d = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_start  <= 1'b0;
      cpu_stall  <= 1'b0;
      fill_armed <= 1'b0;
    end else begin
      dma_start  <= start_d;
      cpu_stall  <= stall_d;
      fill_armed <= armed_d;
    end
  end

  // R6: a stall request only accompanies a start
  a_r6_stall_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> dma_start);

  // R7: armed fill released by a data write starts without stall
  a_r7_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_armed && data_wr && !is_second) |=> (dma_start && !cpu_stall && !fill_armed));

  // R7: never armed and starting at once
  a_r7_arm_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_armed && dma_start));
endmodule

// File: rtl/ctrl_cmd_decoder.sv
module ctrl_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              port_rd,
  input  logic              data_wr,
  input  logic [1:0]        dma_mode,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [REG_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic              cmd_pending,
  output logic              fill_armed,
  output logic              dma_start,
  output logic              cpu_stall
);
  logic     rst_int_n;
  logic     pend_live;
  cw_kind_e kind;

  cmd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    pend_live = cmd_pending && !port_rd;
    if (!ctl_wr)                          kind = CW_NONE;
    else if (pend_live)                   kind = CW_SECOND;
    else if (ctl_wdata[15:14] == REG_TAG) kind = CW_REG;
    else                                  kind = CW_FIRST;
  end

  cmd_regwr #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regwr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .is_reg    (kind == CW_REG),
    .wdata     (ctl_wdata),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata)
  );

  cmd_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .is_first    (kind == CW_FIRST),
    .is_second   (kind == CW_SECOND),
    .rd_clr      (port_rd),
    .wdata       (ctl_wdata),
    .cmd_addr    (cmd_addr),
    .cmd_code    (cmd_code),
    .cmd_pending (cmd_pending)
  );

  cmd_dma_ctl u_dma (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .is_second  (kind == CW_SECOND),
    .code_go    (ctl_wdata[7]),
    .dma_mode   (dma_mode),
    .data_wr    (data_wr),
    .dma_start  (dma_start),
    .cpu_stall  (cpu_stall),
    .fill_armed (fill_armed)
  );

  // R5: a write while pending never becomes a register write
  a_r5_no_strobe_on_second: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_wr && cmd_pending && !port_rd) |=> !reg_we);

  // R1: outputs idle while reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!cmd_pending && !dma_start && !reg_we && !fill_armed));

  // R2: address and code only move on a control write
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_wr |=> ($stable(cmd_addr) && $stable(cmd_code)));
endmodule

// File: tb/ctrl_cmd_decoder_tb.sv
module ctrl_cmd_decoder_tb;
  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [15:0] v;
    logic        dw;
    logic        rc;
    logic [1:0]  mode;
    logic        we;
    logic [4:0]  idx;
    logic [7:0]  dat;
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pend;
    logic        st;
    logic        stl;
    logic        arm;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{4'd2, 1'b1,16'h8A5C,1'b0,1'b0,2'b00, 1'b1,5'd10,8'h5C,16'h0000,6'h00,1'b0,1'b0,1'b0,1'b0}, // R2
    '{4'd3, 1'b1,16'h9812,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h00,1'b0,1'b0,1'b0,1'b0}, // R3
    '{4'd4, 1'b1,16'h4123,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0123,6'h01,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd8, 1'b1,16'h0063,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'hC123,6'h19,1'b0,1'b0,1'b0,1'b0}, // R5 R8
    '{4'd4, 1'b1,16'h7FFF,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'hFFFF,6'h19,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd6, 1'b1,16'h8A80,1'b0,1'b0,2'b01, 1'b0,5'd0, 8'h00,16'h3FFF,6'h21,1'b0,1'b1,1'b1,1'b0}, // R5 R6
    '{4'd4, 1'b1,16'h0004,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0004,6'h20,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd6, 1'b1,16'h00B2,1'b0,1'b0,2'b11, 1'b0,5'd0, 8'h00,16'h8004,6'h2C,1'b0,1'b1,1'b0,1'b0}, // R6
    '{4'd4, 1'b1,16'hC010,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h8010,6'h2F,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd7, 1'b1,16'h0090,1'b0,1'b0,2'b10, 1'b0,5'd0, 8'h00,16'h0010,6'h27,1'b0,1'b0,1'b0,1'b1}, // R7
    '{4'd7, 1'b0,16'h0000,1'b1,1'b0,2'b10, 1'b0,5'd0, 8'h00,16'h0010,6'h27,1'b0,1'b1,1'b0,1'b0}, // R7
    '{4'd7, 1'b0,16'h0000,1'b1,1'b0,2'b10, 1'b0,5'd0, 8'h00,16'h0010,6'h27,1'b0,1'b0,1'b0,1'b0}, // R7
    '{4'd4, 1'b1,16'h4000,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h25,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd9, 1'b0,16'h0000,1'b0,1'b1,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h25,1'b0,1'b0,1'b0,1'b0}, // R9
    '{4'd4, 1'b1,16'h0001,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0001,6'h24,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd9, 1'b1,16'h8105,1'b0,1'b1,2'b00, 1'b1,5'd1, 8'h05,16'h0001,6'h24,1'b0,1'b0,1'b0,1'b0}, // R9
    '{4'd4, 1'b1,16'h0000,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h24,1'b1,1'b0,1'b0,1'b0}, // R4
    '{4'd7, 1'b1,16'h0080,1'b0,1'b0,2'b10, 1'b0,5'd0, 8'h00,16'h0000,6'h20,1'b0,1'b0,1'b0,1'b1}, // R7
    '{4'd4, 1'b1,16'h0000,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h20,1'b1,1'b0,1'b0,1'b1}, // R4
    '{4'd8, 1'b1,16'h0000,1'b0,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h00,1'b0,1'b0,1'b0,1'b0}, // R8
    '{4'd8, 1'b0,16'h0000,1'b1,1'b0,2'b00, 1'b0,5'd0, 8'h00,16'h0000,6'h00,1'b0,1'b0,1'b0,1'b0}, // R8
    '{4'd3, 1'b1,16'h9701,1'b0,1'b0,2'b00, 1'b1,5'd23,8'h01,16'h0000,6'h00,1'b0,1'b0,1'b0,1'b0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [15:0] ctl_wdata;
  logic        port_rd;
  logic        data_wr;
  logic [1:0]  dma_mode;
  logic        reg_we;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic [15:0] cmd_addr;
  logic [5:0]  cmd_code;
  logic        cmd_pending;
  logic        fill_armed;
  logic        dma_start;
  logic        cpu_stall;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ctrl_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .port_rd(port_rd), .data_wr(data_wr), .dma_mode(dma_mode),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_pending(cmd_pending),
    .fill_armed(fill_armed), .dma_start(dma_start), .cpu_stall(cpu_stall)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] v, input logic dw,
                       input logic rc, input logic [1:0] m);
    ctl_wr = wr; ctl_wdata = v; data_wr = dw; port_rd = rc; dma_mode = m;
    @(posedge clk);
    #2;
    ctl_wr = 1'b0; data_wr = 1'b0; port_rd = 1'b0;
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "cmd_pending", 32'(cmd_pending), 32'd0);
    chk(tag, "cmd_addr",    32'(cmd_addr),    32'd0);
    chk(tag, "cmd_code",    32'(cmd_code),    32'd0);
    chk(tag, "reg_we",      32'(reg_we),      32'd0);
    chk(tag, "dma_start",   32'(dma_start),   32'd0);
    chk(tag, "cpu_stall",   32'(cpu_stall),   32'd0);
    chk(tag, "fill_armed",  32'(fill_armed),  32'd0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; port_rd = 1'b0;
    data_wr = 1'b0; dma_mode = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk_idle("R1");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      drive(TBL[i].wr, TBL[i].v, TBL[i].dw, TBL[i].rc, TBL[i].mode);
      chk(tag, "reg_we",      32'(reg_we),      32'(TBL[i].we));
      if (TBL[i].we) begin
        chk(tag, "reg_idx",   32'(reg_idx),     32'(TBL[i].idx));
        chk(tag, "reg_wdata", 32'(reg_wdata),   32'(TBL[i].dat));
      end
      chk(tag, "cmd_addr",    32'(cmd_addr),    32'(TBL[i].addr));
      chk(tag, "cmd_code",    32'(cmd_code),    32'(TBL[i].code));
      chk(tag, "cmd_pending", 32'(cmd_pending), 32'(TBL[i].pend));
      chk(tag, "dma_start",   32'(dma_start),   32'(TBL[i].st));
      chk(tag, "cpu_stall",   32'(cpu_stall),   32'(TBL[i].stl));
      chk(tag, "fill_armed",  32'(fill_armed),  32'(TBL[i].arm));
    end

    // R2: strobe gone one cycle later
    drive(1'b0, 16'h0000, 1'b0, 1'b0, 2'b00);
    chk("R2", "reg_we after pulse", 32'(reg_we), 32'd0);

    // R1: reset during a half-written command clears everything at once
    drive(1'b1, 16'h4123, 1'b0, 1'b0, 2'b00);
    chk("R4", "cmd_pending", 32'(cmd_pending), 32'd1);
    rst_n = 1'b0;
    #1;
    chk_idle("R1");
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R5: with nothing pending after reset, a 10-tagged word is a register write
    drive(1'b1, 16'h8233, 1'b0, 1'b0, 2'b00);
    chk("R2", "reg_we after reset", 32'(reg_we), 32'd1);
    chk("R2", "reg_idx after reset", 32'(reg_idx), 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule